// File: doc/BRIEF.md
# Conditional Register Adder-Subtractor

This block holds two operand registers, an accumulator register A and a source register B, both `WIDTH` bits wide. A single ripple-carry adder serves both arithmetic operations. When the operation enable is high, A is replaced at the clock edge by B + A or by B − A, depending on the subtract select. Subtraction reuses the same adder. The select inverts every bit of the A operand and also forms the carry-in, so the adder computes B + ~A + 1. A carry flag and a signed-overflow flag are captured in the same edge as the result.

Each register has its own synchronous preset port for loading operands. Control is decoded each cycle into one of four named operations:

- `OP_HOLD`: no write.
- `OP_PRESET`: A takes its preset data.
- `OP_ADD`: A takes B + A.
- `OP_SUB`: A takes B − A.

A preset of A takes priority over the arithmetic enable. Register B changes only through its own preset. The decode is a priority selection redone every cycle, with no stored sequencing state: any operation may follow any other in the next cycle. The only transition is the synchronous reset, which forces A, B and both flags to zero.

Top module: `reg_addsub`

## Requirements
- R1: With `op_en`=1, `sub_sel`=0 and `a_preset`=0, at the clock edge `a_q` becomes (`b_q` + `a_q`) mod 2^WIDTH.
- R2: With `op_en`=1, `sub_sel`=1 and `a_preset`=0, at the clock edge `a_q` becomes `b_q` + (bitwise NOT `a_q`) + 1 mod 2^WIDTH, i.e. `b_q` − `a_q` in two's complement.
- R3: On every arithmetic write, `carry_q` takes the carry out of the most significant adder bit. For addition this is 1 when the unsigned sum exceeds 2^WIDTH−1. For subtraction it is 1 exactly when `b_q` ≥ `a_q` as unsigned numbers.
- R4: With `op_en`=0 and `a_preset`=0, `a_q`, `carry_q` and `ovf_q` keep their values.
- R5: With `a_preset`=1, `a_q` takes `a_din` at the clock edge whatever `op_en` is. `carry_q` and `ovf_q` keep their values in that cycle.
- R6: `b_q` takes `b_din` when `b_preset`=1 and otherwise never changes. An arithmetic operation in the same cycle uses the value `b_q` had before the edge.
- R7: On every arithmetic write, `ovf_q` is the XOR of the carries into and out of the most significant bit. It is therefore 1 exactly when both adder operands (`b_q` and the possibly inverted `a_q`) share a sign bit and the result's sign bit differs from it. An example with WIDTH=4 is 7 + 1 = 1000, which sets `ovf_q`.
- R8: A synchronous reset (`rst`=1 at a clock edge) clears `a_q`, `b_q`, `carry_q` and `ovf_q` to zero and overrides every other input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_preset | input | 1 | Load `a_din` into register A |
| a_din | input | WIDTH | Preset data for register A |
| b_preset | input | 1 | Load `b_din` into register B |
| b_din | input | WIDTH | Preset data for register B |
| sub_sel | input | 1 | 0 selects B + A, 1 selects B − A |
| op_en | input | 1 | Arithmetic enable; result written into A |
| a_q | output | WIDTH | Register A contents |
| b_q | output | WIDTH | Register B contents |
| carry_q | output | 1 | Registered carry out of the MSB |
| ovf_q | output | 1 | Registered signed overflow |

## Verification
The bench targets several corner cases, each of which a faulty design would show at the ports:

- Positive overflow (7 + 1) and negative overflow (−8 + −8). A flag taken from the wrong carry would miss these.
- Subtraction with equal operands, and subtraction of zero. A missing carry-in would give results off by one and a carry of 0 where 1 is expected.
- A preset of A issued together with the enable. If arithmetic won, A would hold the sum instead of the preset value, or the flags would change.
- A preset of B in the same cycle as an operation. The result would show the new B if the operand were read late.

Long runs with the enable low, followed by random operation mixes, expose any drift in A, in B or in the held flags.

// File: rtl/reg_addsub_pkg.sv
package reg_addsub_pkg;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_PRESET = 2'd1,
        OP_ADD    = 2'd2,
        OP_SUB    = 2'd3
    } op_e;

endpackage

// File: rtl/reg_addsub_opsel.sv
module reg_addsub_opsel #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_val,
    input  logic             sub_sel,
    output logic [WIDTH-1:0] operand,
    output logic             carry_in
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_inv
            assign operand[gi] = a_val[gi] ^ sub_sel;
        end
    endgenerate

    assign carry_in = sub_sel;

endmodule

// File: rtl/reg_addsub_ripple.sv
module reg_addsub_ripple #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             c_in,
    output logic [WIDTH-1:0] sum,
    output logic             c_into_msb,
    output logic             c_out
);

    logic [WIDTH:0] chain;

    assign chain[0] = c_in;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_fa
            assign sum[gi]     = x_in[gi] ^ y_in[gi] ^ chain[gi];
            assign chain[gi+1] = (x_in[gi] & y_in[gi]) |
                                 (chain[gi] & (x_in[gi] ^ y_in[gi]));
        end
    endgenerate

    assign c_into_msb = chain[WIDTH-1];
    assign c_out      = chain[WIDTH];

endmodule

// File: rtl/reg_addsub_ctrl.sv
module reg_addsub_ctrl
    import reg_addsub_pkg::*;
(
    input  logic a_preset,
    input  logic op_en,
    input  logic sub_sel,
    output op_e  op
);

    always_comb begin
        if (a_preset) begin
            op = OP_PRESET;
        end else if (op_en) begin
            op = sub_sel ? OP_SUB : OP_ADD;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/reg_addsub.sv
module reg_addsub
    import reg_addsub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_preset,
    input  logic [WIDTH-1:0] a_din,
    input  logic             b_preset,
    input  logic [WIDTH-1:0] b_din,
    input  logic             sub_sel,
    input  logic             op_en,
    output logic [WIDTH-1:0] a_q,
    output logic [WIDTH-1:0] b_q,
    output logic             carry_q,
    output logic             ovf_q
);

    localparam int MSB = WIDTH - 1;

    op_e              op;
    logic [WIDTH-1:0] operand;
    logic             carry_in;
    logic [WIDTH-1:0] sum;
    logic             c_into_msb;
    logic             c_out;

    logic [WIDTH-1:0] a_next;
    logic             carry_next;
    logic             ovf_next;

    reg_addsub_ctrl u_ctrl (
        .a_preset (a_preset),
        .op_en    (op_en),
        .sub_sel  (sub_sel),
        .op       (op)
    );

    reg_addsub_opsel #(.WIDTH(WIDTH)) u_opsel (
        .a_val    (a_q),
        .sub_sel  (sub_sel),
        .operand  (operand),
        .carry_in (carry_in)
    );

    reg_addsub_ripple #(.WIDTH(WIDTH)) u_adder (
        .x_in       (b_q),
        .y_in       (operand),
        .c_in       (carry_in),
        .sum        (sum),
        .c_into_msb (c_into_msb),
        .c_out      (c_out)
    );

    always_comb begin
        a_next     = a_q;
        carry_next = carry_q;
        ovf_next   = ovf_q;
        unique case (op)
            OP_HOLD: begin
            end
            OP_PRESET: begin
                a_next = a_din;
            end
            OP_ADD, OP_SUB: begin
                a_next     = sum;
                carry_next = c_out;
                ovf_next   = c_into_msb ^ c_out;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            carry_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            a_q     <= a_next;
            carry_q <= carry_next;
            ovf_q   <= ovf_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else if (b_preset) begin
            b_q <= b_din;
        end
    end

    // R1
    add_result_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && !a_preset && !sub_sel) |=> a_q == $past(b_q) + $past(a_q));

    // R2
    sub_result_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && !a_preset && sub_sel) |=> a_q == $past(b_q) - $past(a_q));

    // R3
    add_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && !a_preset && !sub_sel) |=>
        carry_q == (((WIDTH+1)'($past(b_q)) + (WIDTH+1)'($past(a_q))) > (WIDTH+1)'({WIDTH{1'b1}})));

    // R3
    sub_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && !a_preset && sub_sel) |=> carry_q == ($past(b_q) >= $past(a_q)));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_en && !a_preset) |=> ($stable(a_q) && $stable(carry_q) && $stable(ovf_q)));

    // R5
    preset_wins_chk: assert property (@(posedge clk) disable iff (rst)
        a_preset |=> (a_q == $past(a_din) && $stable(carry_q) && $stable(ovf_q)));

    // R6
    b_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        !b_preset |=> $stable(b_q));

    // R7
    ovf_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (op_en && !a_preset) |=>
        ovf_q == (($past(b_q[MSB]) == ($past(a_q[MSB]) ^ $past(sub_sel))) &&
                  (a_q[MSB] != $past(b_q[MSB]))));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (a_q == '0 && b_q == '0 && !carry_q && !ovf_q));

endmodule

// File: tb/reg_addsub_test.sv
module reg_addsub_test;

    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         a_preset;
    logic [W-1:0] a_din;
    logic         b_preset;
    logic [W-1:0] b_din;
    logic         sub_sel;
    logic         op_en;
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic         carry_q;
    logic         ovf_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_a = 0, m_b = 0, m_c = 0, m_v = 0;

    always #5 clk = ~clk;

    reg_addsub #(.WIDTH(W)) uut (
        .clk      (clk),
        .rst      (rst),
        .a_preset (a_preset),
        .a_din    (a_din),
        .b_preset (b_preset),
        .b_din    (b_din),
        .sub_sel  (sub_sel),
        .op_en    (op_en),
        .a_q      (a_q),
        .b_q      (b_q),
        .carry_q  (carry_q),
        .ovf_q    (ovf_q)
    );

    task automatic compare(input string tag);
        checks++;
        if (int'(a_q) != m_a || int'(b_q) != m_b ||
            int'(carry_q) != m_c || int'(ovf_q) != m_v) begin
            fails++;
            $display("FAIL %s: a=%0d b=%0d c=%0d v=%0d expected a=%0d b=%0d c=%0d v=%0d",
                     tag, a_q, b_q, carry_q, ovf_q, m_a, m_b, m_c, m_v);
        end
    endtask

    task automatic step(input bit r, input bit pa, input int da, input bit pb,
                        input int db, input bit sb, input bit en, input string tag);
        int opd, tot, nb, na, nc, nv;
        rst      = r;
        a_preset = pa;
        a_din    = W'(da);
        b_preset = pb;
        b_din    = W'(db);
        sub_sel  = sb;
        op_en    = en;
        na = m_a; nb = m_b; nc = m_c; nv = m_v;
        if (r) begin
            na = 0; nb = 0; nc = 0; nv = 0;
        end else begin
            if (pb) nb = db & MASK;
            if (pa) begin
                na = da & MASK;
            end else if (en) begin
                opd = sb ? ((~m_a) & MASK) : m_a;
                tot = m_b + opd + (sb ? 1 : 0);
                na  = tot & MASK;
                nc  = (tot >> W) & 1;
                nv  = ((((m_b >> (W-1)) & 1) == ((opd >> (W-1)) & 1)) &&
                       (((na >> (W-1)) & 1) != ((m_b >> (W-1)) & 1))) ? 1 : 0;
            end
        end
        @(posedge clk);
        m_a = na; m_b = nb; m_c = nc; m_v = nv;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; a_preset = 0; a_din = '0; b_preset = 0; b_din = '0;
        sub_sel = 0; op_en = 0;
        @(negedge clk);
        step(1, 1, 5, 1, 9, 0, 1, "R8 reset overrides inputs");
        step(0, 1, 3, 1, 4, 0, 0, "R5 preset A, R6 preset B");
        step(0, 0, 0, 0, 0, 0, 1, "R1 add 4+3");
        step(0, 1, 1, 1, 7, 0, 0, "R5 load 1, R6 load 7");
        step(0, 0, 0, 0, 0, 0, 1, "R7 positive overflow 7+1");
        step(0, 1, 8, 1, 8, 0, 0, "R5 load -8");
        step(0, 0, 0, 0, 0, 0, 1, "R3 R7 -8 + -8 carry and overflow");
        step(0, 1, 6, 1, 6, 0, 0, "R6 load equal operands");
        step(0, 0, 0, 0, 0, 1, 1, "R2 R3 subtract equal");
        step(0, 1, 0, 1, 5, 0, 0, "R5 load zero");
        step(0, 0, 0, 0, 0, 1, 1, "R2 subtract zero");
        step(0, 1, 9, 1, 2, 0, 0, "R5 load 9");
        step(0, 0, 0, 0, 0, 1, 1, "R3 subtract borrow 2-9");
        step(0, 1, 11, 0, 0, 1, 1, "R5 preset wins over enable");
        for (int i = 0; i < 8; i++)
            step(0, 0, 0, 0, 0, i[0], 0, "R4 hold with enable low");
        step(0, 0, 0, 1, 13, 0, 1, "R6 add uses old B during B preset");
        step(0, 0, 0, 0, 0, 1, 1, "R2 subtract with new B");
        step(1, 0, 0, 0, 0, 0, 0, "R8 mid-run reset");
        for (int i = 0; i < 400; i++) begin
            int rv;
            rv = int'($urandom());
            step(((rv >> 20) & 63) == 0, ((rv >> 8) & 7) == 0, rv & MASK,
                 ((rv >> 11) & 3) == 0, (rv >> 4) & MASK,
                 rv[13], rv[14] | rv[15], "R1 R2 R3 R7 random mix");
        end
        finish_run();
    end

endmodule